// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a 32-pin general-purpose I/O bank seen by software as a small word-addressed register file. Pin direction, the output latch and the interrupt configuration are never written directly. Each one has a pair of addresses. A one written to the "set" address turns bits on, and a one written to the "clear" address turns them off. Zero bits in either write leave the register alone, so two agents can change separate pins without a read-modify-write race. Every input passes through a two-stage synchronizer before it is read or used for detection.

The eight lowest pins can also raise interrupts. Each has a rise-enable bit, a fall-enable bit, a level-mode bit and a debounce bit. In edge mode the rise and fall bits pick which transitions latch a sticky status bit. In level mode the same two bits choose active-high or active-low sensing, and the status bit is set again on every cycle the level stays active. Software clears status bits by writing ones to the acknowledge address. A single `irq` output is the OR of the status bits whose pin still has a rise or fall enable. When debounce is on, a small per-pin state machine accepts a new input level only after it has held for `DB_CYCLES` clocks. The machine waits in FLT_IDLE. It moves to FLT_QUAL on a mismatch, returns to FLT_IDLE if the input reverts, and also returns to FLT_IDLE, committing the new level, when its counter expires.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), the output latch is 0, the interrupt-configuration word is 0, all status bits are 0 and `irq` is 0.
- R2: A write to offset 0x04 makes the pins with a one in the data outputs, and a write to 0x08 makes them inputs. The direction word reads at 0x00, 0x04 and 0x08, and `pin_oe` equals it.
- R3: A write to 0x10 sets output-latch bits and a write to 0x14 clears them. The latch reads at 0x10 and 0x14, and `pin_out` equals it.
- R4: Offset 0x0C reads all 32 pin inputs after a two-flop synchronizer.
- R5: The interrupt-configuration word is changed by set (0x18) and clear (0x1C) writes and reads at both offsets. Its fields are rise-enable [7:0], fall-enable [15:8], debounce [23:16] and level-mode [31:24], bit n of each field belonging to pin n.
- R6: With level-mode 0, a rising edge on pin n latches status bit n if its rise bit is set, and a falling edge does so if its fall bit is set. With both bits set, either edge latches it. The bit stays set until acknowledged.
- R7: With level-mode 1, the rise bit selects active-high sensing and the fall bit active-low sensing. The status bit is set again after an acknowledge for as long as the level stays active.
- R8: Writing a one to bit n of 0x20 clears status bit n. Status reads at 0x24 in bits [7:0], and bits [31:8] read as 0.
- R9: `irq` is 1 exactly when some status bit is set whose pin has its rise or fall bit set. Clearing both bits masks the pin without clearing its status.
- R10: Pins 8 to 31 never set a status bit or drive `irq`.
- R11: With pin n's debounce bit set, an input level held for fewer than `DB_CYCLES` (default 4) clocks is ignored, and a level held longer is accepted.
- R12: Writes to the read-only offsets 0x00, 0x0C and 0x24 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable, 1 = pin drives |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong direction, latch or configuration bit shows at once: on `pin_oe` or `pin_out`, or on the read of its offset in the cycle after the write. A detector that is wrong, or a filter stuck in FLT_QUAL, shows as a status bit or an `irq` level that differs from the expected value a few cycles after an input change: two synchronizer stages plus one detection register, plus `DB_CYCLES` when debounce is on. An acknowledge that fails, or level status that does not come back, shows on the status read one cycle after the write to 0x20.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int IRQ_PINS  = 8;

    localparam logic [ADDR_W-1:0] OFS_DIR_RD   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_OUT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR_IN   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_PIN_RD   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_ICFG_SET = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_ICFG_CLR = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_IACK     = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ISTAT    = 6'h24;

    typedef enum logic [0:0] {
        FLT_IDLE = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;

    // Field order matters: software decodes these bit positions.
    typedef struct packed {
        logic [IRQ_PINS-1:0] lvl;
        logic [IRQ_PINS-1:0] deb;
        logic [IRQ_PINS-1:0] fall;
        logic [IRQ_PINS-1:0] rise;
    } icfg_t;

endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_bank_pkg::*;
#(
    parameter int DB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    flt_state_e st_q, st_n;
    logic       acc_q, acc_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_IDLE;
            acc_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            acc_q <= acc_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        acc_n = acc_q;
        cnt_n = cnt_q;
        if (!en) begin
            st_n  = FLT_IDLE;
            acc_n = din;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                FLT_IDLE: begin
                    if (din != acc_q) begin
                        st_n  = FLT_QUAL;
                        cnt_n = '0;
                    end
                end
                FLT_QUAL: begin
                    if (din == acc_q) begin
                        st_n = FLT_IDLE;
                    end else if (cnt_q == CNT_LAST) begin
                        acc_n = din;
                        st_n  = FLT_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: st_n = FLT_IDLE;
            endcase
        end
    end

    assign dout = en ? acc_q : din;

    AST_FLT_COMMIT_FROM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (acc_q != $past(acc_q))) |-> ($past(st_q) == FLT_QUAL)); // R11

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_bank_pkg::*;
#(
    parameter int DB_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_PINS-1:0] lvl_in,
    input  icfg_t               cfg,
    input  logic [IRQ_PINS-1:0] ack,
    output logic [IRQ_PINS-1:0] stat,
    output logic                irq
);

    logic [IRQ_PINS-1:0] filt;
    logic [IRQ_PINS-1:0] prev_q;
    logic [IRQ_PINS-1:0] evt;

    for (genvar i = 0; i < IRQ_PINS; i++) begin : g_pin
        gpio_pin_filter #(.DB_CYCLES(DB_CYCLES)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (cfg.deb[i]),
            .din  (lvl_in[i]),
            .dout (filt[i])
        );

        always_comb begin
            if (cfg.lvl[i])
                evt[i] = (cfg.rise[i] & filt[i]) | (cfg.fall[i] & ~filt[i]);
            else
                evt[i] = (cfg.rise[i] & filt[i] & ~prev_q[i])
                       | (cfg.fall[i] & ~filt[i] & prev_q[i]);
        end

        AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> $past(cfg.rise[i] | cfg.fall[i])); // R6
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat   <= '0;
        end else begin
            prev_q <= filt;
            stat   <= evt | (stat & ~ack);
        end
    end

    assign irq = |(stat & (cfg.rise | cfg.fall));

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.rise | cfg.fall) == '0) |-> !irq); // R9

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int DB_CYCLES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic              irq
);

    localparam int STAT_PAD = DATA_W - IRQ_PINS;

    logic [DATA_W-1:0] sync_q [SYNC_STAGES];
    logic [DATA_W-1:0] pin_sync;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] dout_q;
    icfg_t             cfg_q;
    logic [IRQ_PINS-1:0] ack;
    logic [IRQ_PINS-1:0] irq_stat;
    logic              wr;

    // Input synchronizer chain
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sync_q[s] <= '0;
            else if (s == 0)
                sync_q[s] <= pin_in;
            else
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end
    assign pin_sync = sync_q[SYNC_STAGES-1];

    assign wr = bus_valid && bus_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            cfg_q  <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_DIR_OUT:  dir_q  <= dir_q  |  bus_wdata;
                OFS_DIR_IN:   dir_q  <= dir_q  & ~bus_wdata;
                OFS_DOUT_SET: dout_q <= dout_q |  bus_wdata;
                OFS_DOUT_CLR: dout_q <= dout_q & ~bus_wdata;
                OFS_ICFG_SET: cfg_q  <= cfg_q  |  bus_wdata;
                OFS_ICFG_CLR: cfg_q  <= cfg_q  & ~bus_wdata;
                default: ;
            endcase
        end
    end

    assign ack = (wr && bus_addr == OFS_IACK) ? bus_wdata[IRQ_PINS-1:0] : '0;

    gpio_irq_unit #(.DB_CYCLES(DB_CYCLES)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_in(pin_sync[IRQ_PINS-1:0]),
        .cfg   (cfg_q),
        .ack   (ack),
        .stat  (irq_stat),
        .irq   (irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_DIR_RD, OFS_DIR_OUT, OFS_DIR_IN: bus_rdata = dir_q;
            OFS_PIN_RD:                          bus_rdata = pin_sync;
            OFS_DOUT_SET, OFS_DOUT_CLR:          bus_rdata = dout_q;
            OFS_ICFG_SET, OFS_ICFG_CLR:          bus_rdata = cfg_q;
            OFS_ISTAT:                           bus_rdata = {{STAT_PAD{1'b0}}, irq_stat};
            default:                             bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    AST_DIR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_DIR_OUT) |=> ((dir_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_DOUT_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_DOUT_CLR) |=> ((dout_q & $past(bus_wdata)) == '0)); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_IACK && (cfg_q.rise | cfg_q.fall) == '0)
        |=> ((irq_stat & $past(bus_wdata[IRQ_PINS-1:0])) == '0)); // R8

endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // {req, write offset, write data, read offset, expected read}
    localparam logic [83:0] VEC [NVEC] = '{
        {8'd2,  6'h04, 32'h0000_00F0, 6'h00, 32'h0000_00F0}, // R2 set outputs
        {8'd2,  6'h08, 32'h0000_0030, 6'h00, 32'h0000_00C0}, // R2 set inputs
        {8'd12, 6'h00, 32'h0000_FFFF, 6'h04, 32'h0000_00C0}, // R12 direction readback write
        {8'd3,  6'h10, 32'h0000_00A5, 6'h10, 32'h0000_00A5}, // R3 latch set
        {8'd3,  6'h14, 32'h0000_0005, 6'h14, 32'h0000_00A0}, // R3 latch clear
        {8'd5,  6'h18, 32'h0101_0203, 6'h18, 32'h0101_0203}, // R5 config set
        {8'd5,  6'h1C, 32'h0100_0000, 6'h1C, 32'h0001_0203}, // R5 config clear
        {8'd5,  6'h1C, 32'hFFFF_FFFF, 6'h18, 32'h0000_0000}, // R5 config clear all
        {8'd12, 6'h0C, 32'hFFFF_FFFF, 6'h10, 32'h0000_00A0}  // R12 pin readback write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input int rq, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d got=%h exp=%h", rq, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(1, pin_oe, 32'h0);
        chk(1, pin_out, 32'h0);
        chk(1, {31'h0, irq}, 32'h0);
        rd(6'h18, rv); chk(1, rv, 32'h0);
        rd(6'h24, rv); chk(1, rv, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][75:70], VEC[i][69:38]);
            rd(VEC[i][37:32], rv);
            chk(int'(VEC[i][83:76]), rv, VEC[i][31:0]);
        end
        chk(2, pin_oe, 32'h0000_00C0);  // R2
        chk(3, pin_out, 32'h0000_00A0); // R3

        // R4 synchronized input read
        pin_in = 32'h1234_5678;
        idle(3);
        rd(6'h0C, rv); chk(4, rv, 32'h1234_5678);
        pin_in = '0;
        idle(4);
        wr(6'h20, 32'hFF);

        // R6 rising only on pin 0
        wr(6'h18, 32'h0000_0001);
        pin_in[0] = 1'b1; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h01);
        chk(9, {31'h0, irq}, 32'h1);
        wr(6'h20, 32'h01);
        rd(6'h24, rv); chk(8, rv, 32'h00);
        chk(9, {31'h0, irq}, 32'h0);
        pin_in[0] = 1'b0; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h00);
        // R6 falling only on pin 1
        wr(6'h18, 32'h0000_0200);
        pin_in[1] = 1'b1; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h00);
        pin_in[1] = 1'b0; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h02);
        wr(6'h20, 32'h02);
        // R6 both edges on pin 2
        wr(6'h18, 32'h0000_0404);
        pin_in[2] = 1'b1; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h04);
        wr(6'h20, 32'h04);
        pin_in[2] = 1'b0; idle(5);
        rd(6'h24, rv); chk(6, rv, 32'h04);
        wr(6'h20, 32'h04);
        rd(6'h24, rv); chk(8, rv, 32'h00);
        wr(6'h1C, 32'hFFFF_FFFF);

        // R7 active-high level on pin 3
        wr(6'h18, 32'h0800_0008);
        idle(3);
        rd(6'h24, rv); chk(7, rv, 32'h00);
        pin_in[3] = 1'b1; idle(5);
        rd(6'h24, rv); chk(7, rv, 32'h08);
        wr(6'h20, 32'h08);
        rd(6'h24, rv); chk(7, rv, 32'h08);
        pin_in[3] = 1'b0; idle(5);
        wr(6'h20, 32'h08);
        rd(6'h24, rv); chk(7, rv, 32'h00);
        // R7 active-low level on pin 4
        wr(6'h18, 32'h1000_1000);
        idle(3);
        rd(6'h24, rv); chk(7, rv, 32'h10);
        pin_in[4] = 1'b1; idle(5);
        wr(6'h20, 32'h10);
        rd(6'h24, rv); chk(7, rv, 32'h00);
        chk(7, {31'h0, irq}, 32'h0);
        wr(6'h1C, 32'hFFFF_FFFF);
        pin_in[4] = 1'b0; idle(5);
        wr(6'h20, 32'hFF);

        // R9 masking keeps status, drops irq
        wr(6'h18, 32'h0000_0020);
        pin_in[5] = 1'b1; idle(5);
        chk(9, {31'h0, irq}, 32'h1);
        wr(6'h1C, 32'h0000_0020);
        #1 chk(9, {31'h0, irq}, 32'h0);
        rd(6'h24, rv); chk(9, rv, 32'h20);
        wr(6'h20, 32'h20);
        pin_in[5] = 1'b0; idle(5);

        // R10 upper pins never interrupt
        wr(6'h18, 32'h0000_FFFF);
        pin_in = 32'hFFFF_FF00; idle(5);
        rd(6'h24, rv); chk(10, rv, 32'h00);
        chk(10, {31'h0, irq}, 32'h0);
        pin_in = '0; idle(5);
        rd(6'h24, rv); chk(10, rv, 32'h00);
        wr(6'h1C, 32'hFFFF_FFFF);

        // R11 debounce on pin 6
        wr(6'h18, 32'h0000_0040);
        pin_in[6] = 1'b1; idle(2); pin_in[6] = 1'b0; idle(6);
        rd(6'h24, rv); chk(11, rv, 32'h40);
        wr(6'h20, 32'h40);
        wr(6'h18, 32'h0040_0000);
        idle(2);
        pin_in[6] = 1'b1; idle(2); pin_in[6] = 1'b0; idle(10);
        rd(6'h24, rv); chk(11, rv, 32'h00);
        pin_in[6] = 1'b1; idle(12);
        rd(6'h24, rv); chk(11, rv, 32'h40);

        // R12 write to status offset has no effect; R8 upper bits zero
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, rv); chk(12, rv, 32'h40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule